// File: doc/BRIEF.md
# Reorder Buffer Retirement and Squash Controller

This block keeps the in-flight instructions of one thread in program order and retires them in order. The front end dispatches instructions, each tagged with an increasing sequence number. The execute stage marks instructions finished by sequence number and raises redirect requests. Each cycle the controller retires up to a fixed number of finished instructions from the head. It also reports its free-entry count back to the front end.

Some instructions are flagged as not allowed to run speculatively. When such an instruction becomes the oldest entry and has not finished, the controller announces its sequence number once, so the earlier stages can issue it. Redirects are filtered by age against the youngest sequence number the buffer holds. When one is accepted, the controller broadcasts the squash point and the corrected target. It then removes the younger entries from the tail at a bounded rate over as many cycles as needed, and signals when the removal is complete.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the buffer is empty. `free_cnt` equals DEPTH, `youngest_seq` is 0, `disp_ready` is high, and every pulse output is low.
- R2: A dispatch is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low when the buffer is full, while a squash is draining, or while any redirect input is valid. Each accepted dispatch sets `youngest_seq` to its sequence number.
- R3: `cmpl_valid` marks the held entry whose sequence number equals `cmpl_seq` as finished. On each edge, the controller retires the run of finished entries starting at the oldest one, at most COMMIT_WIDTH of them, and the run ends at the first unfinished entry. On the next cycle `retire_cnt` shows how many were retired and `retire_last_seq` shows the sequence number of the youngest one retired.
- R4: When the oldest entry is flagged non-speculative and has not finished, `nonspec_valid` pulses for exactly one cycle with that entry's sequence number in `nonspec_seq`. This happens at most once per entry, and never while a squash drains.
- R5: If several redirect inputs are valid in the same cycle, the one with the smallest sequence number is taken. On a tie, the lowest input index wins. Input i uses bits [i*SEQ_W +: SEQ_W] of `redir_seq` and [i*PC_W +: PC_W] of `redir_target`.
- R6: A redirect is taken only if its sequence number is strictly less than `youngest_seq`. Otherwise it is dropped: no squash pulse appears and `youngest_seq` does not change.
- R7: A taken redirect causes `squash_valid` to pulse on the next cycle, with `squash_seq` and `squash_target` set from the winning request. `youngest_seq` becomes that sequence number.
- R8: During a squash, at most SQUASH_WIDTH entries with sequence numbers greater than the squash point are removed from the tail per cycle. Entries at or below the squash point are kept. `squash_done` pulses once no younger entry remains. For n younger entries this is max(1, ceil(n/SQUASH_WIDTH)) cycles after `squash_valid`.
- R9: No entry retires while a squash drains or while any redirect input is valid.
- R10: `free_cnt` equals DEPTH minus the number of held entries. `free_update` pulses in the cycle after any edge that changed the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_nonspec | input | 1 | Dispatched instruction must not run speculatively |
| disp_ready | output | 1 | Dispatch can be taken this cycle |
| cmpl_valid | input | 1 | Completion mark valid |
| cmpl_seq | input | SEQ_W | Sequence number of the finished instruction |
| redir_valid | input | NUM_REDIR | One valid bit per redirect source |
| redir_seq | input | NUM_REDIR*SEQ_W | Redirect sequence numbers, packed per source |
| redir_target | input | NUM_REDIR*PC_W | Corrected targets, packed per source |
| retire_cnt | output | $clog2(COMMIT_WIDTH+1) | Instructions retired on the last edge |
| retire_last_seq | output | SEQ_W | Youngest sequence number retired on the last edge that retired |
| nonspec_valid | output | 1 | Release pulse for a non-speculative head entry |
| nonspec_seq | output | SEQ_W | Sequence number being released |
| squash_valid | output | 1 | Squash broadcast pulse |
| squash_seq | output | SEQ_W | Squash point; younger instructions are discarded |
| squash_target | output | PC_W | Corrected fetch target |
| squash_done | output | 1 | Squash removal finished |
| free_cnt | output | $clog2(DEPTH)+1 | Free entries |
| free_update | output | 1 | Occupancy changed on the last edge |
| youngest_seq | output | SEQ_W | Youngest valid sequence number |

## Verification
A corrupted head or tail pointer shows up as a wrong `retire_last_seq` the next time something retires. It also shows up as a `free_cnt` that drifts from the count of dispatches minus removals, visible one cycle after the bad edge. A stale youngest-sequence register shows up as a redirect that is accepted or dropped wrongly, which appears on `squash_valid` one cycle later. A miscounted drain shows up as a `squash_done` pulse that comes early or late relative to the number of younger entries. It also shows up as a later squash or retire that names an entry that should have been removed. A lost or repeated release flag appears as a missing or doubled `nonspec_valid` pulse while the same entry stays at the head.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Drain state of the squash engine
  typedef enum logic {SQ_IDLE = 1'b0, SQ_DRAIN = 1'b1} sq_state_e;
endpackage

// File: rtl/rob_redir_pick.sv
// Chooses the oldest valid redirect; lowest index wins ties.
module rob_redir_pick #(
  parameter int N     = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic [N-1:0]       req_valid,
  input  logic [N*SEQ_W-1:0] req_seq,
  input  logic [N*PC_W-1:0]  req_tgt,
  output logic               any_req,
  output logic [SEQ_W-1:0]   win_seq,
  output logic [PC_W-1:0]    win_tgt
);
  always_comb begin
    any_req = 1'b0;
    win_seq = '0;
    win_tgt = '0;
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && (!any_req || req_seq[i*SEQ_W +: SEQ_W] < win_seq)) begin
        win_seq = req_seq[i*SEQ_W +: SEQ_W];
        win_tgt = req_tgt[i*PC_W +: PC_W];
        any_req = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_head_scan.sv
// Counts the run of finished entries from the head, up to CW.
module rob_head_scan #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int CW    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int KW   = $clog2(CW + 1)
) (
  input  logic [AW-1:0]          head_i,
  input  logic [AW:0]            count_i,
  input  logic [DEPTH-1:0]       done_i,
  input  logic [DEPTH*SEQ_W-1:0] seq_i,
  output logic [KW-1:0]          run_o,
  output logic [SEQ_W-1:0]       last_seq_o
);
  logic          stop;
  logic [AW-1:0] idx;
  always_comb begin
    stop       = 1'b0;
    run_o      = '0;
    last_seq_o = '0;
    idx        = '0;
    for (int j = 0; j < CW; j++) begin
      idx = head_i + AW'(j);
      if (!stop && (j < int'(count_i)) && done_i[idx]) begin
        run_o      = run_o + KW'(1);
        last_seq_o = seq_i[idx*SEQ_W +: SEQ_W];
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_tail_scan.sv
// Counts tail entries younger than the squash point, up to SW,
// and tells whether more remain behind them.
module rob_tail_scan #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int SW    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int KW   = $clog2(SW + 1)
) (
  input  logic [AW-1:0]          tail_i,
  input  logic [AW:0]            count_i,
  input  logic [DEPTH*SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0]       point_i,
  output logic [KW-1:0]          take_o,
  output logic                   more_o
);
  logic          stop;
  logic          younger;
  logic [AW-1:0] idx;
  always_comb begin
    stop    = 1'b0;
    take_o  = '0;
    more_o  = 1'b0;
    younger = 1'b0;
    idx     = '0;
    for (int i = 0; i <= SW; i++) begin
      idx     = tail_i - AW'(i + 1);
      younger = (i < int'(count_i)) && (seq_i[idx*SEQ_W +: SEQ_W] > point_i);
      if (i == SW) begin
        more_o = !stop && younger;
      end else if (!stop && younger) begin
        take_o = take_o + KW'(1);
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl #(
  parameter int DEPTH        = 16,
  parameter int SEQ_W        = 16,
  parameter int PC_W         = 32,
  parameter int COMMIT_WIDTH = 2,
  parameter int SQUASH_WIDTH = 2,
  parameter int NUM_REDIR    = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                disp_valid,
  input  logic [SEQ_W-1:0]                    disp_seq,
  input  logic                                disp_nonspec,
  output logic                                disp_ready,
  input  logic                                cmpl_valid,
  input  logic [SEQ_W-1:0]                    cmpl_seq,
  input  logic [NUM_REDIR-1:0]                redir_valid,
  input  logic [NUM_REDIR*SEQ_W-1:0]          redir_seq,
  input  logic [NUM_REDIR*PC_W-1:0]           redir_target,
  output logic [$clog2(COMMIT_WIDTH+1)-1:0]   retire_cnt,
  output logic [SEQ_W-1:0]                    retire_last_seq,
  output logic                                nonspec_valid,
  output logic [SEQ_W-1:0]                    nonspec_seq,
  output logic                                squash_valid,
  output logic [SEQ_W-1:0]                    squash_seq,
  output logic [PC_W-1:0]                     squash_target,
  output logic                                squash_done,
  output logic [$clog2(DEPTH):0]              free_cnt,
  output logic                                free_update,
  output logic [SEQ_W-1:0]                    youngest_seq
);
  import rob_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam int RK_W  = $clog2(COMMIT_WIDTH + 1);
  localparam int DK_W  = $clog2(SQUASH_WIDTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  // Entry storage
  logic [SEQ_W-1:0]       seq_mem [DEPTH];
  logic [DEPTH*SEQ_W-1:0] seq_flat;
  logic [DEPTH-1:0]       done_q;
  logic [DEPTH-1:0]       ns_q;
  logic [DEPTH-1:0]       in_rng;

  logic [AW-1:0]    head_q, tail_q;
  logic [CNT_W-1:0] count_q, count_n;
  logic [SEQ_W-1:0] young_q;
  logic [SEQ_W-1:0] sq_point_q;
  sq_state_e        sq_q;
  logic             ns_sent_q;

  // Decisions of the current cycle
  logic             any_redir, accept, disp_fire, release_ns, drain_end, draining;
  logic [SEQ_W-1:0] win_seq;
  logic [PC_W-1:0]  win_tgt;
  logic [RK_W-1:0]  scan_run, ret_k;
  logic [SEQ_W-1:0] scan_last;
  logic [DK_W-1:0]  scan_take, drain_k;
  logic             scan_more;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      logic [AW-1:0] off;
      assign seq_flat[g*SEQ_W +: SEQ_W] = seq_mem[g];
      assign off       = AW'(g) - head_q;
      assign in_rng[g] = {1'b0, off} < count_q;
    end
  endgenerate

  rob_redir_pick #(.N(NUM_REDIR), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_pick (
    .req_valid (redir_valid),
    .req_seq   (redir_seq),
    .req_tgt   (redir_target),
    .any_req   (any_redir),
    .win_seq   (win_seq),
    .win_tgt   (win_tgt)
  );

  rob_head_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CW(COMMIT_WIDTH)) u_head (
    .head_i     (head_q),
    .count_i    (count_q),
    .done_i     (done_q),
    .seq_i      (seq_flat),
    .run_o      (scan_run),
    .last_seq_o (scan_last)
  );

  rob_tail_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SW(SQUASH_WIDTH)) u_tail (
    .tail_i  (tail_q),
    .count_i (count_q),
    .seq_i   (seq_flat),
    .point_i (sq_point_q),
    .take_o  (scan_take),
    .more_o  (scan_more)
  );

  always_comb begin
    draining   = (sq_q == SQ_DRAIN);
    accept     = any_redir && (win_seq < young_q);
    disp_ready = (count_q != FULL) && !draining && !any_redir;
    disp_fire  = disp_valid && disp_ready;
    ret_k      = (!draining && !any_redir) ? scan_run : '0;
    release_ns = !draining && (count_q != '0) && ns_q[head_q] &&
                 !done_q[head_q] && !ns_sent_q;
    drain_k    = draining ? scan_take : '0;
    drain_end  = draining && !scan_more && !accept;
    count_n    = count_q + CNT_W'(disp_fire) - CNT_W'(ret_k) - CNT_W'(drain_k);
  end

  // Sequence number storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (disp_fire) seq_mem[tail_q] <= disp_seq;
  end

  // Per-entry flags
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      ns_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (disp_fire && (tail_q == AW'(i))) begin
          done_q[i] <= 1'b0;
          ns_q[i]   <= disp_nonspec;
        end else if (cmpl_valid && in_rng[i] && (seq_mem[i] == cmpl_seq)) begin
          done_q[i] <= 1'b1;
        end
      end
    end
  end

  // Pointers, occupancy and squash state
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      young_q    <= '0;
      sq_point_q <= '0;
      sq_q       <= SQ_IDLE;
      ns_sent_q  <= 1'b0;
    end else begin
      head_q  <= head_q + AW'(ret_k);
      tail_q  <= tail_q + AW'(disp_fire) - AW'(drain_k);
      count_q <= count_n;
      if (accept)         young_q <= win_seq;
      else if (disp_fire) young_q <= disp_seq;
      if (accept) begin
        sq_q       <= SQ_DRAIN;
        sq_point_q <= win_seq;
      end else if (drain_end) begin
        sq_q <= SQ_IDLE;
      end
      if (release_ns)                             ns_sent_q <= 1'b1;
      else if ((ret_k != '0) || (count_n == '0))  ns_sent_q <= 1'b0;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      retire_cnt      <= '0;
      retire_last_seq <= '0;
      nonspec_valid   <= 1'b0;
      nonspec_seq     <= '0;
      squash_valid    <= 1'b0;
      squash_seq      <= '0;
      squash_target   <= '0;
      squash_done     <= 1'b0;
      free_cnt        <= FULL;
      free_update     <= 1'b0;
    end else begin
      retire_cnt <= ret_k;
      if (ret_k != '0) retire_last_seq <= scan_last;
      nonspec_valid <= release_ns;
      if (release_ns) nonspec_seq <= seq_mem[head_q];
      squash_valid <= accept;
      if (accept) begin
        squash_seq    <= win_seq;
        squash_target <= win_tgt;
      end
      squash_done <= drain_end;
      free_cnt    <= FULL - count_n;
      free_update <= (count_n != count_q);
    end
  end

  assign youngest_seq = young_q;

  // Assertions
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL) else $error("occupancy above depth");

  assert_free_match_R10: assert property (@(posedge clk) disable iff (rst)
    (free_cnt + count_q) == FULL) else $error("free count mismatch");

  assert_ns_single_R4: assert property (@(posedge clk) disable iff (rst)
    nonspec_valid |=> !nonspec_valid) else $error("repeated release");

  assert_squash_older_R6: assert property (@(posedge clk) disable iff (rst)
    squash_valid |-> (squash_seq < $past(young_q))) else $error("young redirect taken");

  assert_squash_young_R7: assert property (@(posedge clk) disable iff (rst)
    squash_valid |-> (young_q == squash_seq)) else $error("youngest not moved");

  assert_no_retire_drain_R9: assert property (@(posedge clk) disable iff (rst)
    draining |=> (retire_cnt == '0)) else $error("retire during squash");

  assert_ready_low_R2: assert property (@(posedge clk) disable iff (rst)
    (draining || any_redir || count_q == FULL) |-> !disp_ready) else $error("ready high");

  assert_drain_rate_R8: assert property (@(posedge clk) disable iff (rst)
    draining |=> ((int'(count_q) + SQUASH_WIDTH) >= int'($past(count_q))))
    else $error("drain too fast");

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    squash_done |-> !draining) else $error("done while draining");
endmodule

// File: tb/sim_rob_commit_ctrl.sv
module sim_rob_commit_ctrl;
  localparam int CLK_P = 10;
  localparam int D     = 8;
  localparam int SQ_W  = 16;
  localparam int PCW   = 16;
  localparam int CWID  = 2;
  localparam int SWID  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0, disp_nonspec = 1'b0, cmpl_valid = 1'b0;
  logic [SQ_W-1:0] disp_seq = '0, cmpl_seq = '0;
  logic [1:0] redir_valid = '0;
  logic [2*SQ_W-1:0] redir_seq = '0;
  logic [2*PCW-1:0] redir_target = '0;
  logic disp_ready, nonspec_valid, squash_valid, squash_done, free_update;
  logic [1:0] retire_cnt;
  logic [SQ_W-1:0] retire_last_seq, nonspec_seq, squash_seq, youngest_seq;
  logic [PCW-1:0] squash_target;
  logic [3:0] free_cnt;

  always #(CLK_P/2) clk = ~clk;

  rob_commit_ctrl #(.DEPTH(D), .SEQ_W(SQ_W), .PC_W(PCW), .COMMIT_WIDTH(CWID),
                    .SQUASH_WIDTH(SWID), .NUM_REDIR(2)) u0 (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .disp_nonspec(disp_nonspec), .disp_ready(disp_ready), .cmpl_valid(cmpl_valid),
    .cmpl_seq(cmpl_seq), .redir_valid(redir_valid), .redir_seq(redir_seq),
    .redir_target(redir_target), .retire_cnt(retire_cnt),
    .retire_last_seq(retire_last_seq), .nonspec_valid(nonspec_valid),
    .nonspec_seq(nonspec_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
    .squash_target(squash_target), .squash_done(squash_done), .free_cnt(free_cnt),
    .free_update(free_update), .youngest_seq(youngest_seq));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference state built from the requirements
  logic [SQ_W-1:0] mq_seq[$];
  bit mq_done[$];
  bit mq_ns[$];
  logic [SQ_W-1:0] m_young = '0, m_sqpt = '0;
  bit m_sq = 0, m_nssent = 0;
  int next_seq = 10;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit younger_at(input int i, input logic [SQ_W-1:0] pt);
    return mq_seq[i] > pt;
  endfunction

  task automatic tick(input bit dv, input bit dns, input bit cv, input logic [SQ_W-1:0] cs,
                      input bit [1:0] rv, input logic [SQ_W-1:0] rs0, input logic [PCW-1:0] rt0,
                      input logic [SQ_W-1:0] rs1, input logic [PCW-1:0] rt1);
    bit anyr, acc, rdy, fire, rel, more, endd;
    logic [SQ_W-1:0] wseq, relseq, lastseq;
    logic [PCW-1:0] wtgt;
    int k, dk, old_sz;
    @(negedge clk);
    disp_valid = dv; disp_nonspec = dns; disp_seq = SQ_W'(next_seq);
    cmpl_valid = cv; cmpl_seq = cs;
    redir_valid = rv; redir_seq = {rs1, rs0}; redir_target = {rt1, rt0};
    anyr = |rv; wseq = '0; wtgt = '0;
    if (rv[0] && (!rv[1] || rs0 <= rs1)) begin wseq = rs0; wtgt = rt0; end
    else if (rv[1]) begin wseq = rs1; wtgt = rt1; end
    acc  = anyr && (wseq < m_young);
    rdy  = (mq_seq.size() < D) && !m_sq && !anyr;
    fire = dv && rdy;
    #1;
    chk(disp_ready == rdy, "R2", "disp_ready", int'(disp_ready), int'(rdy));
    k = 0; lastseq = '0;
    if (!m_sq && !anyr)
      while (k < CWID && k < mq_seq.size() && mq_done[k]) begin lastseq = mq_seq[k]; k++; end
    rel = !m_sq && mq_seq.size() > 0 && mq_ns[0] && !mq_done[0] && !m_nssent;
    relseq = rel ? mq_seq[0] : '0;
    dk = 0; more = 0;
    if (m_sq) begin
      while (dk < SWID && dk < mq_seq.size() && younger_at(mq_seq.size()-1-dk, m_sqpt)) dk++;
      more = (dk == SWID) && (mq_seq.size() > dk) && younger_at(mq_seq.size()-1-dk, m_sqpt);
    end
    endd = m_sq && !more && !acc;
    if (cv) foreach (mq_seq[i]) if (mq_seq[i] == cs) mq_done[i] = 1;
    old_sz = mq_seq.size();
    repeat (k)  begin void'(mq_seq.pop_front()); void'(mq_done.pop_front()); void'(mq_ns.pop_front()); end
    repeat (dk) begin void'(mq_seq.pop_back());  void'(mq_done.pop_back());  void'(mq_ns.pop_back());  end
    if (fire) begin
      mq_seq.push_back(SQ_W'(next_seq)); mq_done.push_back(0); mq_ns.push_back(dns);
    end
    if (acc) m_young = wseq; else if (fire) m_young = SQ_W'(next_seq);
    if (rel) m_nssent = 1; else if (k > 0 || mq_seq.size() == 0) m_nssent = 0;
    if (acc) begin m_sq = 1; m_sqpt = wseq; end else if (endd) m_sq = 0;
    if (fire) next_seq += 1 + int'($urandom % 2);
    @(posedge clk); #1;
    chk(int'(retire_cnt) == k, "R3", "retire_cnt", int'(retire_cnt), k);
    if (k > 0) chk(retire_last_seq == lastseq, "R3", "retire_last_seq",
                   int'(retire_last_seq), int'(lastseq));
    chk(nonspec_valid == rel, "R4", "nonspec_valid", int'(nonspec_valid), int'(rel));
    if (rel) chk(nonspec_seq == relseq, "R4", "nonspec_seq", int'(nonspec_seq), int'(relseq));
    chk(squash_valid == acc, "R6", "squash_valid", int'(squash_valid), int'(acc));
    if (acc) begin
      chk(squash_seq == wseq, "R5", "squash_seq", int'(squash_seq), int'(wseq));
      chk(squash_target == wtgt, "R7", "squash_target", int'(squash_target), int'(wtgt));
    end
    chk(squash_done == endd, "R8", "squash_done", int'(squash_done), int'(endd));
    chk(int'(free_cnt) == D - mq_seq.size(), "R10", "free_cnt", int'(free_cnt), D - mq_seq.size());
    chk(free_update == (old_sz != mq_seq.size()), "R10", "free_update",
        int'(free_update), int'(old_sz != mq_seq.size()));
    chk(youngest_seq == m_young, "R7", "youngest_seq", int'(youngest_seq), int'(m_young));
  endtask

  task automatic idle(input int n);
    repeat (n) tick(0, 0, 0, '0, 2'b00, '0, '0, '0, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit cv, dv, dns;
    bit [1:0] rv;
    logic [SQ_W-1:0] cs, rs0, rs1;
    int idx;
    $urandom(32'h5eed_0042);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R1: reset state
    chk(disp_ready == 1, "R1", "disp_ready", int'(disp_ready), 1);
    chk(int'(free_cnt) == D, "R1", "free_cnt", int'(free_cnt), D);
    chk(youngest_seq == 0, "R1", "youngest_seq", int'(youngest_seq), 0);
    chk(retire_cnt == 0 && !nonspec_valid && !squash_valid && !squash_done && !free_update,
        "R1", "pulse outputs", 1, 0);

    // R2: fill to full, then one refused dispatch
    repeat (D + 1) tick(1, 0, 0, '0, 2'b00, '0, '0, '0, '0);
    // R3: finish second entry only -> no retire; then head -> run of two
    tick(0, 0, 1, mq_seq[1], 2'b00, '0, '0, '0, '0);
    idle(1);
    tick(0, 0, 1, mq_seq[0], 2'b00, '0, '0, '0, '0);
    idle(2);
    // R5/R8: two redirects, older wins, multi-cycle drain of four entries
    tick(0, 0, 0, '0, 2'b11, mq_seq[3], 16'h1111, mq_seq[1], 16'h2222);
    idle(4);
    // R6: redirect equal to youngest, and one younger, both dropped
    tick(0, 0, 0, '0, 2'b01, m_young, 16'h3333, '0, '0);
    tick(0, 0, 0, '0, 2'b10, '0, '0, m_young + 16'd4, 16'h4444);
    // R4: non-speculative instruction reaches the head
    tick(0, 0, 1, mq_seq[0], 2'b00, '0, '0, '0, '0);
    tick(0, 0, 1, mq_seq[1], 2'b00, '0, '0, '0, '0);
    tick(1, 1, 0, '0, 2'b00, '0, '0, '0, '0);
    idle(3);
    tick(0, 0, 1, mq_seq[0], 2'b00, '0, '0, '0, '0);
    idle(2);
    // R9: redirect present blocks retire of a finished head
    tick(1, 0, 0, '0, 2'b00, '0, '0, '0, '0);
    tick(1, 0, 1, mq_seq[0], 2'b00, '0, '0, '0, '0);
    tick(0, 0, 0, '0, 2'b01, mq_seq[1], 16'h5555, '0, '0);
    idle(3);

    // Constrained random phase
    for (int c = 0; c < 3000; c++) begin
      dv = ($urandom % 4) != 0;
      dns = ($urandom % 8) == 0;
      cv = 0; cs = '0; rv = 2'b00; rs0 = '0; rs1 = '0;
      if (mq_seq.size() > 0 && ($urandom % 2)) begin
        idx = int'($urandom % mq_seq.size());
        cv = !(mq_ns[idx] && !(idx == 0 && m_nssent));
        cs = mq_seq[idx];
      end
      if (($urandom % 12) == 0) begin
        rv[0] = 1;
        rs0 = (mq_seq.size() > 0) ? mq_seq[$urandom % mq_seq.size()] : m_young;
        rv[1] = $urandom % 2;
        rs1 = ($urandom % 3 == 0) ? m_young + 16'd2 :
              (mq_seq.size() > 0) ? mq_seq[$urandom % mq_seq.size()] : m_young;
      end
      tick(dv, dns, cv, cs, rv, rs0, PCW'($urandom), rs1, PCW'($urandom));
    end
    finish_run();
  end
endmodule